// File: doc/BRIEF.md
# Four-Mode Shift/Load Register

This block is an n-bit register whose next value is chosen by a 2-bit mode input on every rising clock edge. The register can keep its contents, take a parallel word, move its contents one place toward the most significant bit, or move them one place toward the least significant bit. Each bit has its own 4-to-1 selector. The selector picks one of four sources for that bit: the bit itself, the matching bit of the parallel input, its lower neighbour or its upper neighbour. The bits that have no neighbour at the two ends take dedicated serial fill inputs.

A parameter turns the block into a combinational-only variant. In that variant the selectors act on the parallel input, and no flip-flops are built. The datapath can then shift or pass an operand within one cycle. A synchronous active-high reset clears the registered variant and takes priority over the mode input.

The mode input has four named values, in the bit order {s1, s0}. HOLD is 00, LOAD is 01, SHL is 10 and SHR is 11. The registered variant has one storage state. Its transitions are RESET to zero, HOLD, LOAD, SHL and SHR, one of which happens at each rising edge.

Top module: `shreg_unit`

## Requirements
- R1: When `rst` is 1 at a rising edge, `q` becomes all zeros at that edge, whatever the values of `mode`, `par_in`, `fill_lo` and `fill_hi`.
- R2: When `mode` is 00 (HOLD) and `rst` is 0 at a rising edge, `q` keeps its previous value.
- R3: When `mode` is 01 (LOAD) and `rst` is 0 at a rising edge, `q` takes the value of `par_in`.
- R4: When `mode` is 10 (SHL) and `rst` is 0 at a rising edge, bit i of `q` takes the old bit i-1 for i ≥ 1, bit 0 takes `fill_lo`, and the old MSB is discarded.
- R5: When `mode` is 11 (SHR) and `rst` is 0 at a rising edge, bit i of `q` takes the old bit i+1 for i < WIDTH-1, the MSB takes `fill_hi`, and the old bit 0 is discarded.
- R6: In the registered variant, `q` changes only at a rising clock edge. Changes on `mode` or `par_in` between edges do not show on `q`.
- R7: With REGISTERED = 0, `q` follows the inputs combinationally. Modes 00 and 01 give `par_in`. Mode 10 gives `{par_in[WIDTH-2:0], fill_lo}`. Mode 11 gives `{fill_hi, par_in[WIDTH-1:1]}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero |
| mode | input | 2 | Operation: 00 hold, 01 load, 10 shift left, 11 shift right |
| par_in | input | WIDTH | Parallel data word |
| fill_lo | input | 1 | Bit shifted into bit 0 on a left shift |
| fill_hi | input | 1 | Bit shifted into the MSB on a right shift |
| q | output | WIDTH | Register contents, or the selector outputs in the combinational variant |

## Verification
Assertions check the reset, hold, load and both shift transitions of the registered variant on every cycle. Each one compares `q` against the value the previous edge's inputs and contents call for. The assertions cannot show R6: an input that changes in the middle of a cycle without reaching `q` is visible only in a bench scenario that probes between edges. The combinational variant of R7 is also checked only by bench scenarios. The assertions also cannot show the ordering of long mixed sequences, such as a reset that arrives while a load is requested, followed by more shifts. The bench scoreboard covers those.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_LOAD = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_SHR  = 2'b11
    } mode_e;

endpackage

// File: rtl/shreg_bit_sel.sv
module shreg_bit_sel
    import shreg_pkg::*;
(
    input  mode_e sel,
    input  logic  own_bit,
    input  logic  load_bit,
    input  logic  lower_bit,
    input  logic  upper_bit,
    output logic  next_bit
);

    always_comb begin
        unique case (sel)
            MODE_HOLD: next_bit = own_bit;
            MODE_LOAD: next_bit = load_bit;
            MODE_SHL:  next_bit = lower_bit;
            MODE_SHR:  next_bit = upper_bit;
            default:   next_bit = own_bit;
        endcase
    end

endmodule

// File: rtl/shreg_next_state.sv
module shreg_next_state
    import shreg_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  mode_e              sel,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   load_val,
    input  logic               fill_lo,
    input  logic               fill_hi,
    output logic [WIDTH-1:0]   nxt
);

    localparam int MSB = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic lower_src;
        logic upper_src;

        if (i == 0) begin : g_lo_end
            assign lower_src = fill_lo;
        end else begin : g_lo_mid
            assign lower_src = cur[i-1];
        end

        if (i == MSB) begin : g_hi_end
            assign upper_src = fill_hi;
        end else begin : g_hi_mid
            assign upper_src = cur[i+1];
        end

        shreg_bit_sel u_sel (
            .sel       (sel),
            .own_bit   (cur[i]),
            .load_bit  (load_val[i]),
            .lower_bit (lower_src),
            .upper_bit (upper_src),
            .next_bit  (nxt[i])
        );
    end

endmodule

// File: rtl/shreg_unit.sv
module shreg_unit
    import shreg_pkg::*;
#(
    parameter int WIDTH      = 4,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             fill_lo,
    input  logic             fill_hi,
    output logic [WIDTH-1:0] q
);

    localparam int MSB = WIDTH - 1;

    mode_e            sel;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;

    assign sel = mode_e'(mode);

    shreg_next_state #(.WIDTH(WIDTH)) u_next (
        .sel      (sel),
        .cur      (cur),
        .load_val (par_in),
        .fill_lo  (fill_lo),
        .fill_hi  (fill_hi),
        .nxt      (nxt)
    );

    if (REGISTERED) begin : g_reg
        logic [WIDTH-1:0] state_q;
        logic             past_ok;

        // State register process
        always_ff @(posedge clk) begin
            if (rst) begin
                state_q <= '0;
            end else begin
                state_q <= nxt;
            end
        end

        always_ff @(posedge clk) begin
            past_ok <= 1'b1;
        end

        // Output process
        always_comb begin
            cur = state_q;
            q   = state_q;
        end

        // R1: reset clears regardless of mode
        a_r1_reset_clears: assert property (@(posedge clk)
            past_ok && $past(rst) |-> q == '0);

        // R2: hold keeps contents
        a_r2_hold_keeps: assert property (@(posedge clk) disable iff (rst)
            past_ok && $past(!rst && mode == 2'b00) |-> $stable(q));

        // R3: load takes the parallel word
        a_r3_load_takes: assert property (@(posedge clk) disable iff (rst)
            past_ok && $past(!rst && mode == 2'b01) |-> q == $past(par_in));

        // R4: left shift with low fill
        a_r4_shift_left: assert property (@(posedge clk) disable iff (rst)
            past_ok && $past(!rst && mode == 2'b10)
            |-> q == {$past(q[MSB-1:0]), $past(fill_lo)});

        // R5: right shift with high fill
        a_r5_shift_right: assert property (@(posedge clk) disable iff (rst)
            past_ok && $past(!rst && mode == 2'b11)
            |-> q == {$past(fill_hi), $past(q[MSB:1])});
    end else begin : g_comb
        // Output process: selectors act on the operand directly
        always_comb begin
            cur = par_in;
            q   = nxt;
        end
    end

endmodule

// File: tb/shreg_unit_test.sv
`timescale 1ns/1ps
module shreg_unit_test;

    localparam int W = 4;

    typedef struct {
        logic [W-1:0] exp;
        string        req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] par_in = '0;
    logic         fill_lo = 1'b0;
    logic         fill_hi = 1'b0;
    logic [W-1:0] q;

    logic [1:0]   c_mode = 2'b00;
    logic [W-1:0] c_par = '0;
    logic         c_flo = 1'b0;
    logic         c_fhi = 1'b0;
    logic [W-1:0] c_q;

    int n_checks = 0;
    int n_fail   = 0;
    logic [W-1:0] model_q = '0;
    item_t sb[$];
    bit done = 1'b0;

    always #2 clk = ~clk;

    shreg_unit #(.WIDTH(W), .REGISTERED(1'b1)) uut (
        .clk(clk), .rst(rst), .mode(mode), .par_in(par_in),
        .fill_lo(fill_lo), .fill_hi(fill_hi), .q(q)
    );

    shreg_unit #(.WIDTH(W), .REGISTERED(1'b0)) uut_comb (
        .clk(clk), .rst(1'b0), .mode(c_mode), .par_in(c_par),
        .fill_lo(c_flo), .fill_hi(c_fhi), .q(c_q)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(logic r, logic [1:0] m, logic [W-1:0] d,
                        logic lo, logic hi, string req);
        item_t it;
        @(negedge clk);
        rst = r; mode = m; par_in = d; fill_lo = lo; fill_hi = hi;
        if (r)              model_q = '0;
        else if (m == 2'b01) model_q = d;
        else if (m == 2'b10) model_q = {model_q[W-2:0], lo};
        else if (m == 2'b11) model_q = {hi, model_q[W-1:1]};
        it.exp = model_q;
        it.req = req;
        sb.push_back(it);
    endtask

    // Monitor: compares after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(it.req, q, it.exp);
        end
    end

    task automatic drain();
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic comb_chk(logic [1:0] m, logic [W-1:0] d, logic lo, logic hi);
        logic [W-1:0] e;
        c_mode = m; c_par = d; c_flo = lo; c_fhi = hi;
        #0.3;
        case (m)
            2'b10:   e = {d[W-2:0], lo};
            2'b11:   e = {hi, d[W-1:1]};
            default: e = d;
        endcase
        chk("R7 comb variant", c_q, e);
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        step(1'b1, 2'b00, 4'h0, 1'b0, 1'b0, "R1 reset state");
        step(1'b1, 2'b01, 4'hF, 1'b1, 1'b1, "R1 reset over load");
        step(1'b0, 2'b01, 4'hA, 1'b0, 1'b0, "R3 load A");
        step(1'b0, 2'b00, 4'h5, 1'b1, 1'b1, "R2 hold ignores par_in");
        step(1'b0, 2'b00, 4'h3, 1'b0, 1'b1, "R2 hold again");
        step(1'b0, 2'b10, 4'h0, 1'b1, 1'b0, "R4 shl fill 1");
        step(1'b0, 2'b10, 4'h0, 1'b0, 1'b1, "R4 shl fill 0");
        step(1'b0, 2'b11, 4'h0, 1'b0, 1'b1, "R5 shr fill 1");
        step(1'b0, 2'b11, 4'h0, 1'b1, 1'b0, "R5 shr fill 0");
        step(1'b0, 2'b01, 4'h9, 1'b0, 1'b0, "R3 load 9");
        step(1'b0, 2'b10, 4'h0, 1'b0, 1'b0, "R4 shl drops MSB");
        step(1'b0, 2'b01, 4'h9, 1'b0, 1'b0, "R3 load 9 again");
        step(1'b0, 2'b11, 4'h0, 1'b0, 1'b0, "R5 shr drops LSB");
        step(1'b1, 2'b10, 4'h0, 1'b1, 1'b1, "R1 reset over shift");
        for (int k = 0; k < 5; k++)
            step(1'b0, 2'b11, 4'h0, 1'b0, 1'b1, "R5 shr fill chain");
        for (int k = 0; k < 5; k++)
            step(1'b0, 2'b10, 4'h0, k[0], 1'b0, "R4 shl fill chain");
        step(1'b0, 2'b01, 4'h6, 1'b0, 1'b0, "R3 load 6");
        step(1'b0, 2'b00, 4'h0, 1'b0, 1'b0, "R2 hold before probe");
        drain();

        // R6: mid-cycle input changes must not reach q
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1.2;
            mode = 2'b01;
            par_in = ~model_q;
            #0.5;
            chk("R6 no change between edges", q, model_q);
            step(1'b0, 2'b00, 4'h0, 1'b0, 1'b0, "R6 hold after probe");
            drain();
        end

        for (int k = 0; k < 24; k++)
            step(1'b0, 2'(k * 7 + 1), 4'(k * 5 + 3), k[1], k[2], "R2 R3 R4 R5 mixed");
        drain();

        for (int k = 0; k < 16; k++)
            comb_chk(2'(k), 4'(k * 3 + 5), k[2], k[3]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule